// File: doc/BRIEF.md
# Transfer Counter with Interrupt Status

This block keeps the bookkeeping for one data transfer between a host memory and a peripheral bus. Software loads a 24-bit remaining byte count. Every time the datapath confirms that a byte has fully completed, the count steps down by one and a 32-bit host address steps up by one. The host address always names the next byte to move, and software can only read it.

Two events from the counter become sticky status flags: the count reaching zero and the count wrapping below zero. Two further flags are set from generic external event inputs. Software clears a flag by writing a one to its position in the status register, and it gives each flag its own enable. Any flag that is set and enabled drives a single registered interrupt line.

Software reaches the block through a small byte-wide register port. The port has an address, write data, a write strobe, a read strobe and registered read data.

Top module: `xfer_tracker`

## Requirements
- R1: After reset the count, the host address, all four status flags, all four enable bits and the irq output are zero.
- R2: The 24-bit count is readable and writable as three bytes at addresses 0x00 (bits 7:0), 0x01 (bits 15:8) and 0x02 (bits 23:16). Each cycle with xfer_ok high and no count write lowers it by exactly one.
- R3: When a decrement takes the count from 1 to 0, status bit 2 (done) is set. A software write of zero to the count does not set it.
- R4: When a decrement takes the count from 0 to 0xFFFFFF, status bit 3 (wrap) is set. Done is not set on that cycle.
- R5: The 32-bit host address reads as four bytes at 0x04 to 0x07, least significant byte first. It increases by one in every cycle with xfer_ok high, and writes to those addresses are ignored.
- R6: A high evt_in[0] sets status bit 0, and a high evt_in[1] sets status bit 1. Flags stay set until cleared. The status register reads at 0x08 in bits 3:0, and bits 7:4 read zero.
- R7: A write to 0x08 clears each status flag whose write-data bit is 1. Flags whose bit is 0 are left unchanged.
- R8: When a flag's set event and its clear write fall in the same cycle, the flag ends up set.
- R9: The enable register at 0x09 holds four bits in 7:0's low nibble, bit n enabling status bit n. After every clock edge, irq equals the OR of (status AND enable) as updated by that edge.
- R10: reg_rdata takes the addressed register's value on the edge where reg_rd is high. It holds its value otherwise, and unmapped addresses read zero.
- R11: A count write in the same cycle as xfer_ok takes priority over the decrement. Neither done nor wrap is set on that cycle, but the host address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| xfer_ok | input | 1 | One byte safely transferred |
| evt_in | input | 2 | External status events (bit 0, bit 1) |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at four edges of the count:
- the 1-to-0 step, where a design that compared against the wrong value would raise done one byte early or late;
- the 0-to-0xFFFFFF step, which a design could miss or mistake for done;
- a software write of zero, which a careless design would treat as reaching done;
- a write landing in the same cycle as a byte strobe, where a design could decrement anyway or flag a false event.

It also drives clear writes together with set events on the same flag, which a clear-first design would lose. It checks that irq drops on the edge that clears the last enabled flag, not one edge later.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int REG_AW = 5;
  localparam int DW     = 8;
  localparam int NSTAT  = 4;

  localparam logic [REG_AW-1:0] A_CNT0  = 5'h00;
  localparam logic [REG_AW-1:0] A_ADDR0 = 5'h04;
  localparam logic [REG_AW-1:0] A_STAT  = 5'h08;
  localparam logic [REG_AW-1:0] A_EN    = 5'h09;

  localparam int B_DMA  = 0;
  localparam int B_PIO  = 1;
  localparam int B_DONE = 2;
  localparam int B_WRAP = 3;
endpackage

// File: rtl/xfer_count.sv
module xfer_count #(
  parameter int CNT_W = 24,
  parameter int HA_W  = 32,
  parameter int DW    = 8,
  localparam int CNT_BYTES = CNT_W / DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_i,
  input  logic [CNT_BYTES-1:0] byte_we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [HA_W-1:0]      haddr_o,
  output logic                 done_evt_o,
  output logic                 wrap_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HA_W-1:0]  haddr_q;
  logic             cnt_en;

  always_comb begin
    cnt_d      = cnt_q;
    done_evt_o = 1'b0;
    wrap_evt_o = 1'b0;
    if (|byte_we_i) begin
      for (int i = 0; i < CNT_BYTES; i++) begin
        if (byte_we_i[i]) cnt_d[i*DW +: DW] = wdata_i;
      end
    end else if (hit_i) begin
      cnt_d      = cnt_q - CNT_W'(1);
      done_evt_o = (cnt_q == CNT_W'(1));
      wrap_evt_o = (cnt_q == '0);
    end
  end

  assign cnt_en = hit_i | (|byte_we_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) haddr_q <= '0;
    else if (hit_i) haddr_q <= haddr_q + HA_W'(1);
  end

  assign cnt_o   = cnt_q;
  assign haddr_o = haddr_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !(|byte_we_i)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt_o |=> (cnt_q == '0)); // R3
  AST_WRAP_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt_o |=> (cnt_q == '1)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (haddr_q == $past(haddr_q) + HA_W'(1))); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|byte_we_i) |-> !(done_evt_o || wrap_evt_o)); // R11
endmodule

// File: rtl/xfer_status.sv
module xfer_status #(
  parameter int NSTAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [NSTAT-1:0] clr_mask_i,
  input  logic             en_we_i,
  input  logic [NSTAT-1:0] en_wdata_i,
  output logic [NSTAT-1:0] stat_o,
  output logic [NSTAT-1:0] en_o,
  output logic             irq_o
);
  logic [NSTAT-1:0] stat_q, stat_d, en_q, en_d, clr_eff;
  logic             irq_q, irq_d;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_comb begin
    stat_d = (stat_q & ~clr_eff) | set_i;
    en_d   = en_we_i ? en_wdata_i : en_q;
    irq_d  = |(stat_d & en_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R8
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((stat_q & $past(clr_mask_i & ~set_i)) == '0)); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == '0) |-> !irq_q); // R9
endmodule

// File: rtl/xfer_rdmux.sv
module xfer_rdmux #(
  parameter int CNT_W = 24,
  parameter int HA_W  = 32,
  parameter int NSTAT = 4,
  localparam int DW = xfer_pkg::DW,
  localparam int AW = xfer_pkg::REG_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [HA_W-1:0]  haddr_i,
  input  logic [NSTAT-1:0] stat_i,
  input  logic [NSTAT-1:0] en_i,
  output logic [DW-1:0]    rdata_o
);
  import xfer_pkg::*;
  localparam int CB = CNT_W / DW;
  localparam int HB = HA_W / DW;

  logic [DW-1:0] sel, rdata_q;

  always_comb begin
    sel = '0;
    for (int i = 0; i < CB; i++)
      if (addr_i == A_CNT0 + AW'(i)) sel = cnt_i[i*DW +: DW];
    for (int j = 0; j < HB; j++)
      if (addr_i == A_ADDR0 + AW'(j)) sel = haddr_i[j*DW +: DW];
    if (addr_i == A_STAT) sel = DW'(stat_i);
    if (addr_i == A_EN)   sel = DW'(en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_q)); // R10
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
  parameter int CNT_W = 24,
  parameter int HA_W  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  input  logic       xfer_ok,
  input  logic [1:0] evt_in,
  output logic       irq
);
  import xfer_pkg::*;
  localparam int CB = CNT_W / DW;

  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic [CB-1:0]    cnt_we;
  logic [CNT_W-1:0] cnt;
  logic [HA_W-1:0]  haddr;
  logic             done_evt, wrap_evt;
  logic [NSTAT-1:0] set_vec, stat, en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  for (genvar g = 0; g < CB; g++) begin : g_cnt_we
    assign cnt_we[g] = reg_wr && (reg_addr == A_CNT0 + REG_AW'(g));
  end

  always_comb begin
    set_vec         = '0;
    set_vec[B_DMA]  = evt_in[0];
    set_vec[B_PIO]  = evt_in[1];
    set_vec[B_DONE] = done_evt;
    set_vec[B_WRAP] = wrap_evt;
  end

  xfer_count #(.CNT_W(CNT_W), .HA_W(HA_W), .DW(DW)) u_count (
    .clk(clk), .rst_n(rst_ni), .hit_i(xfer_ok), .byte_we_i(cnt_we),
    .wdata_i(reg_wdata), .cnt_o(cnt), .haddr_o(haddr),
    .done_evt_o(done_evt), .wrap_evt_o(wrap_evt)
  );

  xfer_status #(.NSTAT(NSTAT)) u_status (
    .clk(clk), .rst_n(rst_ni), .set_i(set_vec),
    .clr_we_i(reg_wr && reg_addr == A_STAT), .clr_mask_i(reg_wdata[NSTAT-1:0]),
    .en_we_i(reg_wr && reg_addr == A_EN), .en_wdata_i(reg_wdata[NSTAT-1:0]),
    .stat_o(stat), .en_o(en), .irq_o(irq)
  );

  xfer_rdmux #(.CNT_W(CNT_W), .HA_W(HA_W), .NSTAT(NSTAT)) u_rd (
    .clk(clk), .rst_n(rst_ni), .rd_i(reg_rd), .addr_i(reg_addr),
    .cnt_i(cnt), .haddr_i(haddr), .stat_i(stat), .en_i(en),
    .rdata_o(reg_rdata)
  );

  AST_ZERO_WRITE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_addr <= 5'd2 && !stat[B_DONE]) |=> !stat[B_DONE]); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> (stat == '0 && !irq)); // R1
endmodule

// File: tb/xfer_tracker_test.sv
module xfer_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, xfer_ok = 1'b0;
  logic [1:0] evt_in = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [23:0] m_cnt;
  logic [31:0] m_addr;
  logic [3:0]  m_stat, m_en;
  logic        m_irq;

  xfer_tracker uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .xfer_ok(xfer_ok), .evt_in(evt_in), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return m_cnt[7:0];
      5'h01: return m_cnt[15:8];
      5'h02: return m_cnt[23:16];
      5'h04: return m_addr[7:0];
      5'h05: return m_addr[15:8];
      5'h06: return m_addr[23:16];
      5'h07: return m_addr[31:24];
      5'h08: return {4'h0, m_stat};
      5'h09: return {4'h0, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic w, input logic [4:0] wa, input logic [7:0] wd,
                      input logic r, input logic h, input logic [1:0] ev, input string req);
    logic [7:0] exp_rd;
    logic [3:0] set;
    logic cw;
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = wa; reg_wdata = wd; xfer_ok = h; evt_in = ev;
    exp_rd = model_read(wa);
    set = {2'b00, ev};
    cw = w && (wa <= 5'h02);
    if (cw) begin
      if (wa == 5'h00) m_cnt[7:0] = wd;
      if (wa == 5'h01) m_cnt[15:8] = wd;
      if (wa == 5'h02) m_cnt[23:16] = wd;
    end else if (h) begin
      if (m_cnt == 24'd1) set[2] = 1'b1;
      if (m_cnt == 24'd0) set[3] = 1'b1;
      m_cnt = m_cnt - 24'd1;
    end
    if (h) m_addr = m_addr + 32'd1;
    if (w && wa == 5'h08) m_stat = m_stat & ~wd[3:0];
    m_stat = m_stat | set;
    if (w && wa == 5'h09) m_en = wd[3:0];
    m_irq = |(m_stat & m_en);
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_rd = 1'b0; xfer_ok = 1'b0; evt_in = '0;
    if (r) check({req, " R10 read"}, {24'h0, reg_rdata}, {24'h0, exp_rd});
    check({req, " R9 irq"}, {31'h0, irq}, {31'h0, m_irq});
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string req);
    step(1'b1, a, d, 1'b0, 1'b0, 2'b00, req);
  endtask
  task automatic rd(input logic [4:0] a, input string req);
    step(1'b0, a, 8'h00, 1'b1, 1'b0, 2'b00, req);
  endtask
  task automatic load_cnt(input logic [23:0] v, input string req);
    wr(5'h00, v[7:0], req); wr(5'h01, v[15:8], req); wr(5'h02, v[23:16], req);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_cnt = '0; m_addr = '0; m_stat = '0; m_en = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 10; a++) rd(a[4:0], "R1 reset value");

    // R3: count from 1 to 0 raises done
    load_cnt(24'h000002, "R2 load");
    step(1'b0, 5'h0, 8'h0, 1'b0, 1'b1, 2'b00, "R2 dec");
    rd(5'h08, "R3 not yet done");
    step(1'b0, 5'h0, 8'h0, 1'b0, 1'b1, 2'b00, "R3 dec to zero");
    rd(5'h08, "R3 done set");
    rd(5'h00, "R2 count zero");
    // R4: wrap from 0
    step(1'b0, 5'h0, 8'h0, 1'b0, 1'b1, 2'b00, "R4 wrap");
    rd(5'h08, "R4 wrap set");
    rd(5'h02, "R4 count max");
    rd(5'h04, "R5 addr byte0");
    // R7: write zero has no effect, then one clears
    wr(5'h08, 8'h00, "R7 zero write");
    rd(5'h08, "R7 unchanged");
    wr(5'h08, 8'h0C, "R7 clear");
    rd(5'h08, "R7 cleared");
    // R3: software write of zero does not set done
    load_cnt(24'h000000, "R3 zero write");
    rd(5'h08, "R3 no done on write");
    // R5: address write ignored
    wr(5'h04, 8'hAA, "R5 write ignored");
    rd(5'h04, "R5 addr unchanged");
    // R9: enable and irq timing
    wr(5'h09, 8'h01, "R9 enable");
    step(1'b0, 5'h0, 8'h0, 1'b0, 1'b0, 2'b01, "R6 evt0 sets irq");
    rd(5'h08, "R6 status evt0");
    wr(5'h08, 8'h01, "R9 irq drops on clear");
    // R8: set and clear together
    step(1'b1, 5'h08, 8'h02, 1'b0, 1'b0, 2'b10, "R8 set beats clear");
    rd(5'h08, "R8 still set");
    // R11: count write with byte strobe
    load_cnt(24'h000001, "R11 load");
    step(1'b1, 5'h00, 8'h01, 1'b0, 1'b1, 2'b00, "R11 write wins");
    rd(5'h00, "R11 count kept");
    rd(5'h08, "R11 no done");
    rd(5'h04, "R11 addr advanced");
    rd(5'h1F, "R10 unmapped");

    for (int n = 0; n < 4000; n++) begin
      logic w, r, h;
      logic [4:0] a;
      logic [7:0] d;
      logic [1:0] ev;
      int sel;
      sel = $urandom_range(0, 7);
      case (sel)
        0, 1, 2: a = 5'h00;
        3: a = 5'h01;
        4: a = 5'h08;
        5: a = 5'h09;
        6: a = 5'h04 + 5'($urandom_range(0, 3));
        default: a = 5'($urandom_range(0, 31));
      endcase
      w = ($urandom_range(0, 5) == 0);
      r = ($urandom_range(0, 2) == 0);
      h = ($urandom_range(0, 1) == 1);
      ev = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00;
      d = 8'($urandom);
      if (a != 5'h08 && a != 5'h09 && a != 5'h00) d = 8'h00;
      else if (a == 5'h00) d = 8'($urandom_range(0, 3));
      step(w, a, d, r, h, ev, "R2 R6 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule